// File: doc/BRIEF.md
# Serial EEPROM Target on a Two-Wire Bus

This block is a two-wire (I2C) target that fronts an internal byte-wide memory of 8192 words. It runs on a system clock and oversamples the serial clock and data lines. It drives the data line only through an open-drain enable, `sda_oe`. A high `sda_oe` pulls the line low. The block recognises bus framing conditions and responds to a device-select byte whose low three address bits come from strapped inputs. It keeps a word pointer that persists between transactions.

A master writes by sending the word pointer and then up to 32 data bytes. These bytes collect in a page buffer. A STOP hands the page to a modelled self-timed write cycle of `WR_CYCLES` system clocks. While that cycle runs, the block does not answer its address, so the master can poll for completion. Reads stream bytes from the pointer until the master withholds its acknowledge. A write-protect input blocks every change to the array.

Top module: `i2c_eeprom_target`

## Requirements
- R1: Bus framing and start-up:
  - A falling data line while the clock is high is a START.
  - A rising data line while the clock is high is a STOP.
  - Until the first START after reset, `sda_oe` stays low whatever the clock and data lines do.
- R2: The device-select byte is, MSB first, `1010`, then three select bits, then a direction bit (1 = read, 0 = write). If the select bits differ from `sel_i`, the block does not acknowledge that byte or any later byte until the next START.
- R3: The block acknowledges a matching select byte, and each byte received in a write, by holding `sda_oe` high for the whole ninth clock high phase. `sda_oe` only changes while the clock is low.
- R4: The two bytes that follow a write select are the word pointer, high byte first. The top three bits of the high byte are ignored.
- R5: A read sends the byte at the pointer MSB first and releases the line for the ninth clock. When the master acknowledges, the next byte comes from the pointer plus one, wrapping at 8191. A read select with no pointer phase reads from the current pointer.
- R6: When the master does not acknowledge a read byte, the block releases the line and keeps it released through any further clocks until a START or STOP.
- R7: Write data goes into a 32-entry page buffer indexed by the pointer's low 5 bits. Those bits wrap within the page, so a 33rd byte replaces the first.
- R8: Buffered data is committed only by a STOP that follows at least one data byte:
  - A transaction with only a pointer phase leaves the array unchanged and starts no write cycle.
  - A START that arrives before the STOP discards the buffered data.
- R9: A commit starts a write cycle of `WR_CYCLES` system clocks. During the cycle the select byte is not acknowledged; after it ends, the select byte is acknowledged again.
- R10: If `wp_i` is high when the STOP arrives, no location changes and no write cycle starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | Open-drain enable; high pulls the data line low |
| sel_i | input | 3 | Strapped select bits compared against the select byte |
| wp_i | input | 1 | Write protect; high blocks all array changes |

## Verification
The hardest situation to reach from the ports is a select byte that lands inside the self-timed write cycle. The master cannot see the cycle start, so the stimulus polls with a write select straight after the committing STOP. A short `WR_CYCLES` lets the first poll fall inside the cycle and a later poll after it, and the bench counts the unacknowledged polls. Page wrap is driven by a 33-byte burst. Discard on an early START is driven by a repeated START in the middle of a write. In both cases the stored bytes are then read back through the normal read path.

// File: rtl/i2c_ee_pkg.sv
package i2c_ee_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_RACK, ST_WAIT
    } bus_st_e;

    typedef enum logic [1:0] {
        K_DEV, K_AHI, K_ALO, K_DATA
    } kind_e;

    localparam logic [3:0] DEV_TYPE = 4'b1010;
endpackage

// File: rtl/i2c_line_sampler.sv
module i2c_line_sampler #(
    parameter int SYNC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    typedef struct packed {
        logic [SYNC:0] scl;
        logic [SYNC:0] sda;
    } smp_t;

    smp_t q, d;

    always_comb begin
        d.scl = {q.scl[SYNC-1:0], scl_i};
        d.sda = {q.sda[SYNC-1:0], sda_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= d;
    end

    logic scl_p, sda_p;
    assign scl_s     = q.scl[SYNC-1];
    assign sda_s     = q.sda[SYNC-1];
    assign scl_p     = q.scl[SYNC];
    assign sda_p     = q.sda[SYNC];
    assign scl_rise  = scl_s & ~scl_p;
    assign scl_fall  = ~scl_s & scl_p;
    assign start_det = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/ee_page_store.sv
module ee_page_store #(
    parameter int ADDR_W    = 13,
    parameter int PAGE_W    = 5,
    parameter int WR_CYCLES = 5000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ld_en,
    input  logic [PAGE_W-1:0]        ld_idx,
    input  logic [7:0]               ld_data,
    input  logic                     discard,
    input  logic                     commit,
    input  logic [ADDR_W-PAGE_W-1:0] commit_page,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic [7:0]               rd_data,
    output logic                     busy
);
    localparam int PAGE  = 1 << PAGE_W;
    localparam int DEPTH = 1 << ADDR_W;
    localparam int CNT_W = $clog2(WR_CYCLES + 1);

    typedef struct packed {
        logic [PAGE-1:0][7:0]       data;
        logic [PAGE-1:0]            valid;
        logic                       busy;
        logic [CNT_W-1:0]           cnt;
        logic [ADDR_W-PAGE_W-1:0]   page;
    } st_t;

    st_t q, d;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [7:0]        wr_data;
    logic [7:0]        mem [DEPTH];

    always_comb begin
        d       = q;
        wr_en   = 1'b0;
        wr_addr = {q.page, q.cnt[PAGE_W-1:0]};
        wr_data = q.data[q.cnt[PAGE_W-1:0]];
        if (q.busy) begin
            d.cnt = q.cnt + 1'b1;
            // one buffered byte per clock in the first PAGE clocks of the cycle
            if (q.cnt < CNT_W'(PAGE) && q.valid[q.cnt[PAGE_W-1:0]])
                wr_en = 1'b1;
            if (q.cnt == CNT_W'(WR_CYCLES - 1)) begin
                d.busy  = 1'b0;
                d.valid = '0;
                d.cnt   = '0;
            end
        end else begin
            if (discard) d.valid = '0;
            if (ld_en) begin
                d.data[ld_idx]  = ld_data;
                d.valid[ld_idx] = 1'b1;
            end
            if (commit) begin
                d.busy = 1'b1;
                d.cnt  = '0;
                d.page = commit_page;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    assign rd_data = mem[rd_addr];
    assign busy    = q.busy;
endmodule

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target
    import i2c_ee_pkg::*;
#(
    parameter int ADDR_W    = 13,
    parameter int PAGE_W    = 5,
    parameter int WR_CYCLES = 5000,
    parameter int SYNC      = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    input  logic [2:0] sel_i,
    input  logic       wp_i
);
    typedef struct packed {
        bus_st_e           st;
        kind_e             kind;
        logic [3:0]        cnt;
        logic [7:0]        sh;
        logic [ADDR_W-1:0] ptr;
        logic              got_data;
        logic              mack;
        logic              rw;
        logic              oe;
    } fsm_t;

    fsm_t q, d;
    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic ld_en, discard, commit, busy;
    logic [7:0] rd_data;
    bus_st_e st_q;

    i2c_line_sampler #(.SYNC(SYNC)) u_smp (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    ee_page_store #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WR_CYCLES(WR_CYCLES)) u_store (
        .clk(clk), .rst_n(rst_n),
        .ld_en(ld_en), .ld_idx(q.ptr[PAGE_W-1:0]), .ld_data(q.sh),
        .discard(discard), .commit(commit),
        .commit_page(q.ptr[ADDR_W-1:PAGE_W]),
        .rd_addr(q.ptr), .rd_data(rd_data), .busy(busy)
    );

    always_comb begin
        d       = q;
        ld_en   = 1'b0;
        discard = 1'b0;
        commit  = 1'b0;
        if (stop_det) begin
            if (q.got_data && !wp_i) commit  = 1'b1;
            else if (q.got_data)     discard = 1'b1;
            d.st       = ST_IDLE;
            d.oe       = 1'b0;
            d.got_data = 1'b0;
        end else if (start_det) begin
            discard    = q.got_data;
            d.st       = ST_RX;
            d.kind     = K_DEV;
            d.cnt      = '0;
            d.oe       = 1'b0;
            d.got_data = 1'b0;
        end else begin
            unique case (q.st)
                ST_RX: begin
                    if (scl_rise && q.cnt != 4'd8) begin
                        d.sh  = {q.sh[6:0], sda_s};
                        d.cnt = q.cnt + 4'd1;
                    end
                    if (scl_fall && q.cnt == 4'd8) begin
                        d.cnt = '0;
                        d.st  = ST_ACK;
                        d.oe  = 1'b1;
                        unique case (q.kind)
                            K_DEV: begin
                                d.rw   = q.sh[0];
                                d.kind = K_AHI;
                                if (q.sh[7:1] != {DEV_TYPE, sel_i} || busy) begin
                                    d.st = ST_WAIT;
                                    d.oe = 1'b0;
                                end
                            end
                            K_AHI: begin
                                d.ptr[ADDR_W-1:8] = q.sh[ADDR_W-9:0];
                                d.kind = K_ALO;
                            end
                            K_ALO: begin
                                d.ptr[7:0] = q.sh;
                                d.kind = K_DATA;
                            end
                            default: begin
                                ld_en = 1'b1;
                                d.ptr[PAGE_W-1:0] = q.ptr[PAGE_W-1:0] + 1'b1;
                                d.got_data = 1'b1;
                            end
                        endcase
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        if (q.rw) begin
                            d.sh  = rd_data;
                            d.ptr = q.ptr + 1'b1;
                            d.st  = ST_TX;
                            d.oe  = ~rd_data[7];
                        end else begin
                            d.st = ST_RX;
                            d.oe = 1'b0;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (q.cnt == 4'd7) begin
                            d.st  = ST_RACK;
                            d.cnt = '0;
                            d.oe  = 1'b0;
                        end else begin
                            d.sh  = {q.sh[6:0], 1'b0};
                            d.cnt = q.cnt + 4'd1;
                            d.oe  = ~q.sh[6];
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) d.mack = ~sda_s;
                    if (scl_fall) begin
                        if (q.mack) begin
                            d.sh  = rd_data;
                            d.ptr = q.ptr + 1'b1;
                            d.st  = ST_TX;
                            d.oe  = ~rd_data[7];
                        end else begin
                            d.st = ST_WAIT;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_IDLE;
            q.kind <= K_DEV;
        end else begin
            q <= d;
        end
    end

    assign sda_oe = q.oe;
    assign st_q   = q.st;
endmodule

// File: rtl/i2c_ee_checker.sv
module i2c_ee_checker
    import i2c_ee_pkg::*;
(
    input logic    clk,
    input logic    rst_n,
    input logic    scl_s,
    input logic    sda_oe,
    input logic    stop_det,
    input logic    busy,
    input logic    wp_i,
    input bus_st_e st
);
    assert_oe_moves_scl_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_s);

    assert_commit_after_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(stop_det));

    assert_wp_blocks_commit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !$past(wp_i));

    assert_no_ack_while_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> st != ST_ACK);

    assert_wait_released_R6: assert property (@(posedge clk) disable iff (!rst_n)
        st == ST_WAIT |-> !sda_oe);
endmodule

bind i2c_eeprom_target i2c_ee_checker u_chk (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe),
    .stop_det(stop_det), .busy(busy), .wp_i(wp_i), .st(st_q)
);

// File: tb/i2c_eeprom_target_test.sv
module i2c_eeprom_target_test;
    localparam int Q   = 10;
    localparam int WRC = 600;

    logic clk = 1'b0, rst_n = 1'b0;
    logic m_scl = 1'b1, m_sda = 1'b1, wp = 1'b0;
    logic [2:0] sel = 3'b101;
    logic sda_oe, sda_line;
    int checks = 0, errors = 0;
    bit done = 0;

    assign sda_line = m_sda & ~sda_oe;
    always #4 clk = ~clk;

    i2c_eeprom_target #(.WR_CYCLES(WRC)) uut (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
        .sda_oe(sda_oe), .sel_i(sel), .wp_i(wp)
    );

    // addr 13 | data 8 | wp 1 | expected 8
    localparam logic [29:0] VEC [5] = '{
        {13'h0010, 8'hA5, 1'b0, 8'hA5},
        {13'h1FFF, 8'h3C, 1'b0, 8'h3C},
        {13'h0010, 8'h77, 1'b1, 8'hA5},
        {13'h0ABC, 8'h5A, 1'b0, 8'h5A},
        {13'h0ABC, 8'h00, 1'b0, 8'h00}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic waitq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic slot(input bit b, output bit s1, output bit s2);
        m_sda = b; waitq();
        m_scl = 1'b1; waitq();
        s1 = sda_line; waitq();
        s2 = sda_line; m_scl = 1'b0; waitq();
    endtask

    task automatic do_start();
        m_sda = 1'b1; waitq(); m_scl = 1'b1; waitq();
        m_sda = 1'b0; waitq(); m_scl = 1'b0; waitq();
    endtask

    task automatic do_stop();
        m_sda = 1'b0; waitq(); m_scl = 1'b1; waitq(); m_sda = 1'b1; waitq();
    endtask

    task automatic wbyte(input logic [7:0] v, output bit ack);
        bit a, b;
        for (int i = 7; i >= 0; i--) slot(v[i], a, b);
        slot(1'b1, a, b);
        ack = !a && !b;
    endtask

    task automatic rbyte(input bit mack, output logic [7:0] v, output bit rel);
        bit a, b;
        for (int i = 7; i >= 0; i--) begin
            slot(1'b1, a, b);
            v[i] = a;
        end
        slot(!mack, a, b);
        rel = a && b;
    endtask

    function automatic logic [7:0] dev(input bit rd);
        return {4'b1010, sel, rd};
    endfunction

    task automatic set_ptr(input logic [15:0] a, output bit ok);
        bit k0, k1, k2;
        do_start();
        wbyte(dev(0), k0); wbyte(a[15:8], k1); wbyte(a[7:0], k2);
        ok = k0 && k1 && k2;
    endtask

    task automatic read_at(input logic [15:0] a, output logic [7:0] v);
        bit ok, k, rel;
        set_ptr(a, ok);
        do_start();
        wbyte(dev(1), k);
        rbyte(1'b0, v, rel);
        do_stop();
    endtask

    task automatic wait_ready(output int polls);
        bit k;
        polls = 0;
        for (int i = 0; i < 40; i++) begin
            do_start(); wbyte(dev(0), k); do_stop();
            if (k) break;
            polls++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        bit ok, k, a, b, rel;
        int polls;
        repeat (5) @(negedge clk);
        chk(sda_oe == 1'b0, "R1 reset released", sda_oe, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R1: clocked select byte with no START is ignored
        m_scl = 1'b0; waitq();
        wbyte(dev(0), k);
        chk(!k, "R1 no ack before START", k, 0);
        m_sda = 1'b1; waitq(); m_scl = 1'b1; waitq();

        // R2: wrong select bits, then further bytes also unanswered
        do_start();
        wbyte({4'b1010, 3'b011, 1'b0}, k);
        chk(!k, "R2 select mismatch no ack", k, 0);
        wbyte(8'h00, k);
        chk(!k, "R2 silent until next START", k, 0);
        do_stop();

        // table-driven single-byte writes and read-backs (R3, R5, R9, R10)
        foreach (VEC[i]) begin
            logic [12:0] ad; logic [7:0] dt, ex; logic wpv;
            {ad, dt, wpv, ex} = VEC[i];
            set_ptr({3'b000, ad}, ok);
            chk(ok, "R3 ack on select and pointer", ok, 1);
            wbyte(dt, k);
            chk(k, "R3 ack on data byte", k, 1);
            wp = wpv;
            do_stop();
            waitq();
            wp = 1'b0;
            wait_ready(polls);
            if (wpv) chk(polls == 0, "R10 no write cycle when protected", polls, 0);
            else     chk(polls >= 1 && polls < 40, "R9 busy then ready", polls, 1);
            read_at({3'b000, ad}, v);
            chk(v == ex, wpv ? "R10 protected location unchanged" : "R5 read-back", v, ex);
        end

        // R7: wrap of the low address bits within a page
        set_ptr(16'h003E, ok);
        wbyte(8'h11, k); wbyte(8'h22, k); wbyte(8'h33, k);
        do_stop(); wait_ready(polls);
        set_ptr(16'h003E, ok);
        do_start(); wbyte(dev(1), k);
        rbyte(1'b1, v, rel);
        chk(v == 8'h11, "R5 first sequential byte", v, 8'h11);
        rbyte(1'b0, v, rel);
        chk(v == 8'h22, "R5 incremented address byte", v, 8'h22);
        chk(rel, "R5 line released on ninth clock", rel, 1);
        // R6: further clocks after NACK stay released
        for (int i = 0; i < 9; i++) begin
            slot(1'b1, a, b);
            chk(a && b, "R6 released after NACK", {a, b}, 3);
        end
        do_stop();
        read_at(16'h0020, v);
        chk(v == 8'h33, "R7 wrap to page start", v, 8'h33);

        // R7: 33 bytes, last replaces the first
        set_ptr(16'h0100, ok);
        for (int i = 0; i < 33; i++) wbyte(8'(i), k);
        do_stop(); wait_ready(polls);
        read_at(16'h0100, v);
        chk(v == 8'h20, "R7 33rd byte overwrote first", v, 8'h20);
        read_at(16'h0101, v);
        chk(v == 8'h01, "R7 second byte kept", v, 8'h01);
        read_at(16'h011F, v);
        chk(v == 8'h1F, "R7 last page byte", v, 8'h1F);

        // R8: pointer-only write, then current-address read
        set_ptr(16'h1FFF, ok);
        do_stop();
        wait_ready(polls);
        chk(polls == 0, "R8 pointer-only write starts no cycle", polls, 0);
        do_start(); wbyte(dev(1), k);
        rbyte(1'b1, v, rel);
        chk(v == 8'h3C, "R5 current address read", v, 8'h3C);
        rbyte(1'b0, v, rel);
        chk(v == 8'h00, "R5 pointer wraps past 8191", v, 8'h00);
        do_stop();

        // R4: top three bits of high pointer byte ignored
        set_ptr(16'hEABC, ok);
        wbyte(8'h99, k);
        do_stop(); wait_ready(polls);
        read_at(16'h0ABC, v);
        chk(v == 8'h99, "R4 upper pointer bits ignored", v, 8'h99);

        // R8: START before STOP discards the page
        set_ptr(16'h0010, ok);
        wbyte(8'h12, k);
        do_start();
        do_stop();
        wait_ready(polls);
        chk(polls == 0, "R8 discarded write starts no cycle", polls, 0);
        read_at(16'h0010, v);
        chk(v == 8'hA5, "R8 discarded data not stored", v, 8'hA5);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule